// File: doc/BRIEF.md
# Programmable Bus Wait-State Controller

This block stretches the data phase of external bus cycles by a programmable number of wait cycles. The number of waits depends on which of sixteen memory blocks the access address falls into. The block index is the top four address bits. One 16-bit control word holds a 2-bit wait count for each pair of neighbouring blocks. Software reads and writes that word through a small register port at a fixed address.

Three regions never use the programmed count:
- Block 0, which is internal ROM, always runs with zero waits.
- The internal RAM window inside block 15 always runs with zero waits.
- The peripheral window inside block 15 is paced only by the ready signal of the addressed peripheral.

The bus side is a valid/ready handshake. The requester raises `bus_valid` with `bus_addr` and `bus_write` and holds all three steady until it sees `bus_ready` high at a rising clock edge. That edge completes the cycle. `bus_ready` is the stretched data-phase ready: while it is low the data phase is held. The requester may not withdraw or change a request that is still waiting. A new request may follow in the very next cycle.

Top module: `bus_wait_ctl`

## Requirements
- R1: The block index is `bus_addr[31:28]`. Field n of the control word (bits 2n+1:2n) sets the waits for blocks 2n and 2n+1.
- R2: For a block governed by its field, a field value v (0 to 3) inserts v waits. `bus_ready` is low for the first v cycles of the bus cycle and high in cycle v, counting the start cycle as cycle 0.
- R3: After reset the control word reads 16'hFFFF, so every programmable block pair starts with three waits.
- R4: The control word is written as a whole 16 bits only when `cfg_addr` equals 32'hFFFFF060 and `cfg_we` is high. Writes to any other address change nothing. A read at that address returns the last value written, and a read at any other address returns 0.
- R5: An access to block 0 completes in its start cycle, with `bus_ready` high in cycle 0, whatever field 0 holds.
- R6: An access to the internal RAM window of block 15 (default 32'hFFFFC000 to 32'hFFFFEFFF) completes in its start cycle, whatever field 7 holds.
- R7: An access to the peripheral window of block 15 (default 32'hFFFFF000 to 32'hFFFFFFFF) ignores field 7. During that cycle `bus_ready` equals `periph_ready`.
- R8: The wait count is taken at the start cycle. A control-word write made while a cycle is waiting does not change that cycle's length and applies from the next cycle on.
- R9: `bus_ready` is low whenever `bus_valid` is low. After a completing edge, a request held high starts a new bus cycle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request present |
| bus_addr | input | 32 | Access address |
| bus_write | input | 1 | Access direction, 1 = write (does not affect timing) |
| bus_ready | output | 1 | Data-phase ready; low stretches the cycle |
| periph_ready | input | 1 | Ready from the addressed on-chip peripheral |
| cfg_we | input | 1 | Control-word write strobe |
| cfg_addr | input | 32 | Control-word access address |
| cfg_wdata | input | 16 | Control-word write data |
| cfg_rdata | output | 16 | Control-word read data |

## Verification
`bus_ready` is a combinational function of the current state and inputs. The bench therefore drives each request just after a falling edge and samples `bus_ready` one time unit later in the same cycle. It counts the low cycles before the first high one and compares that count with the wait count computed from the address class and a shadow copy of the control word. A control-word write lands on the next rising edge, so `cfg_rdata` is checked in the cycle after the write strobe. A write placed inside a waiting cycle is expected to leave that cycle's count unchanged and to change the count of the next one. Peripheral accesses hold `periph_ready` low for a chosen number of sampled cycles, and that number must equal the measured wait count.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  typedef enum logic [1:0] {
    CLS_PROG  = 2'd0,
    CLS_ZERO  = 2'd1,
    CLS_PERI  = 2'd2
  } acc_class_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_PERI = 2'd2
  } wait_state_t;
endpackage

// File: rtl/bwc_cfg_reg.sv
module bwc_cfg_reg #(
  parameter int AW       = 32,
  parameter int PAIRS    = 8,
  parameter int CNT_W    = 2,
  parameter logic [AW-1:0] REG_ADDR = 32'hFFFFF060,
  localparam int REG_W   = PAIRS * CNT_W,
  localparam int SEL_W   = $clog2(PAIRS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic [SEL_W-1:0] pair_sel,
  output logic [CNT_W-1:0] pair_waits
);
  logic [REG_W-1:0] word_q;
  logic             hit;
  logic [CNT_W-1:0] fields [PAIRS];

  assign hit = (cfg_addr == REG_ADDR);

  always_ff @(posedge clk) begin
    if (rst)               word_q <= '1;
    else if (cfg_we && hit) word_q <= cfg_wdata;
  end

  for (genvar g = 0; g < PAIRS; g++) begin : g_field
    assign fields[g] = word_q[g*CNT_W +: CNT_W];
  end

  assign pair_waits = fields[pair_sel];
  assign cfg_rdata  = hit ? word_q : '0;

  AST_RESET_ALL_ONES: assert property (@(posedge clk) rst |=> (word_q == '1)); // R3
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && hit) |=> (word_q == $past(cfg_wdata))); // R4
  AST_MISS_KEEPS: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && hit) |=> $stable(word_q)); // R4
endmodule

// File: rtl/bwc_region_dec.sv
module bwc_region_dec
  import bwc_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] RAM_LO  = 32'hFFFFC000,
  parameter logic [AW-1:0] RAM_HI  = 32'hFFFFEFFF,
  parameter logic [AW-1:0] PERI_LO = 32'hFFFFF000,
  parameter logic [AW-1:0] PERI_HI = 32'hFFFFFFFF,
  parameter int BLK_W = 4,
  localparam int SEL_W = BLK_W - 1,
  localparam logic [BLK_W-1:0] TOP_BLK = '1
) (
  input  logic [AW-1:0]    addr,
  output logic [SEL_W-1:0] pair_sel,
  output acc_class_t       acc_cls
);
  logic [BLK_W-1:0] blk;
  logic in_ram, in_peri;

  assign blk      = addr[AW-1 -: BLK_W];
  assign pair_sel = blk[BLK_W-1:1];
  assign in_ram   = (addr >= RAM_LO) && (addr <= RAM_HI);
  assign in_peri  = (addr >= PERI_LO) && (addr <= PERI_HI);

  always_comb begin
    acc_cls = CLS_PROG;
    if (blk == '0)                          acc_cls = CLS_ZERO;
    else if (blk == TOP_BLK && in_ram)      acc_cls = CLS_ZERO;
    else if (blk == TOP_BLK && in_peri)     acc_cls = CLS_PERI;
  end
endmodule

// File: rtl/bwc_wait_fsm.sv
module bwc_wait_fsm
  import bwc_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  acc_class_t       acc_cls,
  input  logic [CNT_W-1:0] waits,
  input  logic             periph_ready,
  output logic             ready,
  output logic             idle
);
  wait_state_t      state_q;
  logic [CNT_W-1:0] cnt_q;

  assign idle = (state_q == ST_IDLE);

  always_comb begin
    ready = 1'b0;
    if (valid) begin
      unique case (state_q)
        ST_IDLE: begin
          unique case (acc_cls)
            CLS_ZERO: ready = 1'b1;
            CLS_PERI: ready = periph_ready;
            default:  ready = (waits == '0);
          endcase
        end
        ST_MEM:  ready = (cnt_q == '0);
        ST_PERI: ready = periph_ready;
        default: ready = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (valid && !ready) begin
          if (acc_cls == CLS_PERI) state_q <= ST_PERI;
          else begin
            state_q <= ST_MEM;
            cnt_q   <= CNT_W'(waits - 1'b1);
          end
        end
        ST_MEM: begin
          if (cnt_q != '0)       cnt_q   <= CNT_W'(cnt_q - 1'b1);
          else if (valid && ready) state_q <= ST_IDLE;
        end
        ST_PERI: if (valid && ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_NO_READY_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
    !valid |-> !ready); // R9
  AST_MEM_ENDS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MEM && valid && cnt_q == '0) |-> ready); // R2
  AST_MEM_STEPS_DOWN: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MEM && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8
  AST_PERI_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PERI && valid) |-> (ready == periph_ready)); // R7
endmodule

// File: rtl/bus_wait_ctl.sv
module bus_wait_ctl
  import bwc_pkg::*;
#(
  parameter int AW     = 32,
  parameter int PAIRS  = 8,
  parameter int CNT_W  = 2,
  parameter logic [AW-1:0] REG_ADDR = 32'hFFFFF060,
  parameter logic [AW-1:0] RAM_LO   = 32'hFFFFC000,
  parameter logic [AW-1:0] RAM_HI   = 32'hFFFFEFFF,
  parameter logic [AW-1:0] PERI_LO  = 32'hFFFFF000,
  parameter logic [AW-1:0] PERI_HI  = 32'hFFFFFFFF,
  localparam int REG_W = PAIRS * CNT_W,
  localparam int SEL_W = $clog2(PAIRS),
  localparam int BLK_W = SEL_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_valid,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_write,
  output logic             bus_ready,
  input  logic             periph_ready,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata
);
  logic [SEL_W-1:0] pair_sel;
  logic [CNT_W-1:0] pair_waits;
  acc_class_t       acc_cls;
  logic             fsm_idle;
  logic             unused_dir;

  assign unused_dir = bus_write;

  bwc_cfg_reg #(.AW(AW), .PAIRS(PAIRS), .CNT_W(CNT_W), .REG_ADDR(REG_ADDR)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pair_sel(pair_sel), .pair_waits(pair_waits)
  );

  bwc_region_dec #(.AW(AW), .RAM_LO(RAM_LO), .RAM_HI(RAM_HI),
                   .PERI_LO(PERI_LO), .PERI_HI(PERI_HI), .BLK_W(BLK_W)) u_dec (
    .addr(bus_addr), .pair_sel(pair_sel), .acc_cls(acc_cls)
  );

  bwc_wait_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .valid(bus_valid), .acc_cls(acc_cls),
    .waits(pair_waits), .periph_ready(periph_ready),
    .ready(bus_ready), .idle(fsm_idle)
  );

  AST_ROM_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
    (fsm_idle && bus_valid && bus_addr[AW-1 -: BLK_W] == '0) |-> bus_ready); // R5
  AST_RAM_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
    (fsm_idle && bus_valid && bus_addr >= RAM_LO && bus_addr <= RAM_HI
     && bus_addr[AW-1 -: BLK_W] == '1) |-> bus_ready); // R6
  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |=> !fsm_idle); // R8
endmodule

// File: tb/sim_bus_wait_ctl.sv
module sim_bus_wait_ctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_write = 1'b0;
  logic        bus_ready;
  logic        periph_ready = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;

  localparam logic [31:0] REGA = 32'hFFFFF060;
  int errors = 0;
  int checks = 0;
  logic [15:0] shadow = 16'hFFFF;

  always #5 clk = ~clk;

  bus_wait_ctl u0 (.*);

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected waits; kperi = cycles periph_ready is held low
  function automatic int exp_waits(logic [31:0] a, logic [15:0] w, int kperi);
    logic [3:0] b = a[31:28];
    if (b == 4'd0) return 0;
    if (b == 4'hF && a >= 32'hFFFFC000 && a <= 32'hFFFFEFFF) return 0;
    if (b == 4'hF && a >= 32'hFFFFF000) return kperi;
    return int'(w[2*b[3:1] +: 2]);
  endfunction

  task automatic cfg_write(logic [31:0] a, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == REGA) shadow = d;
  endtask

  task automatic cfg_read_chk(string req, logic [31:0] a, logic [15:0] exp);
    cfg_addr = a;
    #1;
    chk(req, int'(cfg_rdata), int'(exp));
  endtask

  // one bus cycle; optional control write during first wait cycle
  task automatic access(string req, logic [31:0] a, int kperi, bit mid_wr,
                        logic [15:0] mid_data);
    int n = 0;
    int exp = exp_waits(a, shadow, kperi);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_write = $urandom_range(0, 1) == 1;
    periph_ready = (kperi == 0);
    #1;
    while (!bus_ready && n < 20) begin
      if (n == 0 && mid_wr) begin
        cfg_we = 1'b1; cfg_addr = REGA; cfg_wdata = mid_data;
      end
      @(negedge clk);
      cfg_we = 1'b0;
      if (n == 0 && mid_wr) shadow = mid_data;
      n++;
      periph_ready = (n >= kperi);
      #1;
    end
    chk(req, n, exp);
    @(posedge clk);
    #1;
    bus_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R3 reset value and three waits everywhere programmable
    cfg_read_chk("R3", REGA, 16'hFFFF);
    access("R3", 32'h2000_0010, 0, 0, '0);
    // R4 write at wrong address ignored, other-address read is 0
    cfg_write(32'hFFFFF062, 16'h0000);
    cfg_read_chk("R4", REGA, 16'hFFFF);
    cfg_read_chk("R4", 32'hFFFFF064, 16'h0000);
    // R1/R2: per-pair fields 0..7 = 0,1,2,3,0,1,2,3
    cfg_write(REGA, 16'hE4E4);
    cfg_read_chk("R4", REGA, 16'hE4E4);
    for (int b = 1; b < 15; b++) begin
      access("R1", {b[3:0], 28'h0000100}, 0, 0, '0);
    end
    access("R2", 32'hF000_0000, 0, 0, '0);
    // R5 block 0 zero waits despite field 0 = 3
    cfg_write(REGA, 16'hFFFF);
    access("R5", 32'h0000_0040, 0, 0, '0);
    access("R5", 32'h0FFF_FFFC, 0, 0, '0);
    // R6 RAM window edges
    access("R6", 32'hFFFF_C000, 0, 0, '0);
    access("R6", 32'hFFFF_EFFF, 0, 0, '0);
    access("R2", 32'hFFFF_BFFC, 0, 0, '0);
    // R7 peripheral window follows periph_ready
    cfg_write(REGA, 16'h0000);
    access("R7", 32'hFFFF_F060, 4, 0, '0);
    access("R7", 32'hFFFF_F000, 0, 0, '0);
    cfg_write(REGA, 16'hFFFF);
    access("R7", 32'hFFFF_FFFC, 1, 0, '0);
    // R8 write mid-cycle: this cycle keeps 3, next uses 0
    access("R8", 32'hE000_0000, 0, 1, 16'h0000);
    access("R8", 32'hE000_0000, 0, 0, '0);
    // R9 no ready without valid, back-to-back zero-wait
    #1; chk("R9", int'(bus_ready), 0);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = 32'h0000_0000; #1;
    chk("R9", int'(bus_ready), 1);
    @(negedge clk); #1;
    chk("R9", int'(bus_ready), 1);
    bus_valid = 1'b0;
    // random mix
    for (int i = 0; i < 300; i++) begin
      int sel = $urandom_range(0, 9);
      logic [31:0] a = $urandom;
      if (sel == 0) cfg_write(REGA, 16'($urandom));
      if (sel == 1) a = 32'hFFFFC000 + 32'($urandom_range(0, 32'h2FFF));
      if (sel == 2) a = 32'hFFFFF000 + 32'($urandom_range(0, 32'hFFF));
      access("R2", a, $urandom_range(0, 4), $urandom_range(0, 7) == 0, 16'($urandom));
    end
    cfg_read_chk("R4", REGA, shadow);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule